// File: doc/BRIEF.md
# Multi-Lane Stream Rule Monitor

This block watches one valid/ready stream and never drives it. The stream carries several element lanes. It also carries a set of end-of-sequence flags for each lane, one flag per nesting level. A lower and an upper lane index select the active lanes, a strobe enables each lane, and a user field rides along with the payload. A compile-time complexity level decides which source guarantees apply. A low level means the source has promised more, so the monitor enforces more rules. A high level means fewer guarantees, and the monitor only enforces the unconditional rules.

Every clock edge, the monitor tests the handshake, the lane indices, the rules gated by complexity and the nesting of end flags. Nesting is tracked across transfers by one register that remembers whether any lane has been active since the last innermost terminator. That register is updated lane by lane, from lane 0 upward.

A three-state machine follows the handshake:
- ST_IDLE: no transfer is pending.
- ST_STALL: a transfer was shown without acceptance. Valid and the whole payload must hold.
- ST_OPEN: a transfer was accepted but did not close its sequence, and the complexity forbids a gap. Valid must stay high.

The transitions are:
- Any state goes to ST_STALL on valid without ready.
- Any state goes to ST_OPEN on an accepted transfer that leaves the sequence open at a gap-free complexity.
- Every other case goes to ST_IDLE.

Each violation class has its own sticky flag and a one-cycle pulse on the cycle it is first seen.

Top module: `stream_rule_monitor`

## Requirements
- R1: A low rst_n sampled at a clock edge clears all sticky flags except bit 0. Bit 0 is loaded with s_valid at that edge. While rst_n is low, err_pulse bit 0 equals s_valid.
- R2: If a transfer is shown without ready, the next cycle must still have valid high and an identical payload (data, end flags, both indices, strobe, user). Otherwise the hold class (bit 1) is raised.
- R3: On a valid cycle, the range class (bit 2) is raised when the lower index is LANES or more, the upper index is LANES or more, or the upper index is below the lower index.
- R4: At a complexity below 8, a valid cycle whose strobe bits are not all equal raises the strobe class (bit 3).
- R5: At a complexity below 8, any end flag set in a lane other than the top lane raises the lane-flag class (bit 4). At 8 or above these flags are allowed.
- R6: Below complexity 6, a non-zero lower index raises bit 5. Below complexity 5, an all-zero end field combined with an upper index other than LANES-1 raises bit 6.
- R7: Below complexity 4, the postponed-flag class (bit 7) is raised in two cases. The first is an end flag for level j>0 in a lane without all lower levels set in that lane. The second is an innermost end flag on an inactive lane after some lane was active since the previous innermost end flag.
- R8: Below complexity 3, after an accepted transfer whose top-lane end field is zero, a following cycle with valid low raises the gap class (bit 8). Below complexity 2 the same holds unless that field is all ones.
- R9: At any complexity, the nesting class (bit 9) is raised by an end flag for level j>0 without all lower levels set in the same lane, while a lane has been active (this lane included, in increasing lane order) since the most recent innermost end flag. The innermost end flag is level 0, bit lane*DIMS.
- R10: A detected class raises its err_pulse bit only on the first cycle its sticky flag is clear. After that the sticky bit stays set until reset.
- R11: A lane is active when its strobe bit is set and its index lies between the lower and upper index, inclusive. The end flag for lane i, level j is bit i*DIMS+j of s_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| s_valid | input | 1 | stream valid |
| s_ready | input | 1 | stream ready |
| s_data | input | LANES*ELEM_W | lane payloads |
| s_last | input | LANES*DIMS | end flags, lane major |
| s_lo_idx | input | IDX_W | first active lane index |
| s_hi_idx | input | IDX_W | last active lane index |
| s_lane_en | input | LANES | per-lane strobe |
| s_user | input | USER_W | transfer user field |
| err_sticky | output | NERR | sticky violation flags |
| err_pulse | output | NERR | first-detection pulses |

## Verification
The bench runs two monitors side by side on the same stream, one at complexity 1 and one at complexity 8. Legal traffic at the high level, such as a postponed close on an empty-strobe transfer or end flags in low lanes, must stay silent there and must be flagged at the low level.

The corner cases and the wrong behaviour each one exposes:
- A fully inactive transfer closing an empty sequence must not be called postponed. A monitor that ignores the activity register would flag it.
- An upper index equal to LANES must be caught. A comparison truncated to the index width would miss it.
- A payload changing during a stall must be caught. A monitor that recaptures on every stalled cycle would miss it.
- A partial top-lane close at complexity 1 must raise a gap. A monitor using the complexity-2 rule would pass it.

// File: rtl/smon_pkg.sv
package smon_pkg;
    localparam int NERR   = 10;
    localparam int E_RST  = 0;
    localparam int E_HOLD = 1;
    localparam int E_RNG  = 2;
    localparam int E_STRB = 3;
    localparam int E_LLN  = 4;
    localparam int E_LO   = 5;
    localparam int E_HI   = 6;
    localparam int E_POST = 7;
    localparam int E_GAP  = 8;
    localparam int E_NEST = 9;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_OPEN  = 2'd2
    } hs_state_e;
endpackage

// File: rtl/smon_lane_rules.sv
module smon_lane_rules
    import smon_pkg::*;
#(
    parameter int LANES = 3,
    parameter int DIMS  = 2,
    parameter int CPLX  = 8,
    parameter int IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid,
    input  logic                  ready,
    input  logic [LANES*DIMS-1:0] last,
    input  logic [IDX_W-1:0]      lo_idx,
    input  logic [IDX_W-1:0]      hi_idx,
    input  logic [LANES-1:0]      lane_en,
    output logic [NERR-1:0]       rule_err
);
    localparam bit CHK_UNIFORM = (CPLX < 8);
    localparam bit CHK_LO      = (CPLX < 6);
    localparam bit CHK_HI      = (CPLX < 5);
    localparam bit CHK_POST    = (CPLX < 4);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(LANES - 1);

    logic             seen_q;
    logic             seen_nxt;
    logic [LANES-1:0] act;
    logic             post_v;
    logic             nest_v;
    logic             lln_v;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            act[i] = lane_en[i] && (int'(lo_idx) <= i) && (int'(hi_idx) >= i);
        end
    end

    always_comb begin
        logic s;
        logic low;
        s      = seen_q;
        post_v = 1'b0;
        nest_v = 1'b0;
        lln_v  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (act[i]) s = 1'b1;
            if (last[i*DIMS] && !act[i] && s) post_v = 1'b1;
            low = last[i*DIMS];
            for (int j = 1; j < DIMS; j++) begin
                if (last[i*DIMS+j] && !low) begin
                    post_v = 1'b1;
                    if (s) nest_v = 1'b1;
                end
                low = low & last[i*DIMS+j];
            end
            if (last[i*DIMS]) s = 1'b0;
            if ((i < LANES - 1) && (|last[i*DIMS +: DIMS])) lln_v = 1'b1;
        end
        seen_nxt = s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              seen_q <= 1'b0;
        else if (valid && ready) seen_q <= seen_nxt;
    end

    always_comb begin
        rule_err = '0;
        if (valid) begin
            rule_err[E_RNG]  = (int'(lo_idx) >= LANES) || (int'(hi_idx) >= LANES) ||
                               (hi_idx < lo_idx);
            rule_err[E_STRB] = CHK_UNIFORM && !((&lane_en) || !(|lane_en));
            rule_err[E_LLN]  = CHK_UNIFORM && lln_v;
            rule_err[E_LO]   = CHK_LO && (lo_idx != '0);
            rule_err[E_HI]   = CHK_HI && !(|last) && (hi_idx != TOP_IDX);
            rule_err[E_POST] = CHK_POST && post_v;
            rule_err[E_NEST] = nest_v;
        end
    end
endmodule

// File: rtl/smon_handshake_fsm.sv
module smon_handshake_fsm
    import smon_pkg::*;
#(
    parameter int PW   = 8,
    parameter int DIMS = 2,
    parameter int CPLX = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic            ready,
    input  logic [PW-1:0]   payload,
    input  logic [DIMS-1:0] top_last,
    output logic            hold_err,
    output logic            gap_err
);
    localparam bit NO_GAP = (CPLX < 3);

    hs_state_e       state_q;
    hs_state_e       state_d;
    logic [PW-1:0]   held_q;
    logic            closes;

    generate
        if (CPLX < 2) begin : g_full_close
            assign closes = &top_last;
        end else begin : g_any_close
            assign closes = |top_last;
        end
    endgenerate

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_STALL, ST_OPEN: begin
                if (valid && !ready)                          state_d = ST_STALL;
                else if (valid && ready && NO_GAP && !closes) state_d = ST_OPEN;
                else                                          state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (valid && !ready && state_q != ST_STALL) held_q <= payload;
        end
    end

    always_comb begin
        hold_err = 1'b0;
        gap_err  = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_STALL: hold_err = !valid || (payload != held_q);
            ST_OPEN:  gap_err  = !valid;
            default:  ;
        endcase
    end
endmodule

// File: rtl/smon_err_bank.sv
module smon_err_bank
    import smon_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  logic [NERR-1:0] det,
    output logic [NERR-1:0] sticky,
    output logic [NERR-1:0] pulse
);
    logic [NERR-1:0] rst_vec;

    always_comb begin
        rst_vec        = '0;
        rst_vec[E_RST] = valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky        <= '0;
            sticky[E_RST] <= valid;
        end else begin
            sticky <= sticky | det;
        end
    end

    assign pulse = rst_n ? (det & ~sticky) : rst_vec;

    generate
        for (genvar k = 0; k < NERR; k++) begin : g_chk
            p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                sticky[k] |=> sticky[k]);
            p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
                pulse[k] |=> !pulse[k]);
            p_pulse_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
                pulse[k] |=> sticky[k]);
        end
    endgenerate
endmodule

// File: rtl/stream_rule_monitor.sv
module stream_rule_monitor
    import smon_pkg::*;
#(
    parameter int LANES  = 3,
    parameter int DIMS   = 2,
    parameter int ELEM_W = 8,
    parameter int USER_W = 4,
    parameter int CPLX   = 8,
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    s_valid,
    input  logic                    s_ready,
    input  logic [LANES*ELEM_W-1:0] s_data,
    input  logic [LANES*DIMS-1:0]   s_last,
    input  logic [IDX_W-1:0]        s_lo_idx,
    input  logic [IDX_W-1:0]        s_hi_idx,
    input  logic [LANES-1:0]        s_lane_en,
    input  logic [USER_W-1:0]       s_user,
    output logic [NERR-1:0]         err_sticky,
    output logic [NERR-1:0]         err_pulse
);
    localparam int PW = LANES*ELEM_W + LANES*DIMS + 2*IDX_W + LANES + USER_W;

    logic [PW-1:0]   payload;
    logic [NERR-1:0] rule_err;
    logic [NERR-1:0] det;
    logic            hold_err;
    logic            gap_err;

    assign payload = {s_data, s_last, s_lo_idx, s_hi_idx, s_lane_en, s_user};

    smon_lane_rules #(.LANES(LANES), .DIMS(DIMS), .CPLX(CPLX), .IDX_W(IDX_W)) u_rules (
        .clk(clk), .rst_n(rst_n), .valid(s_valid), .ready(s_ready),
        .last(s_last), .lo_idx(s_lo_idx), .hi_idx(s_hi_idx),
        .lane_en(s_lane_en), .rule_err(rule_err)
    );

    smon_handshake_fsm #(.PW(PW), .DIMS(DIMS), .CPLX(CPLX)) u_fsm (
        .clk(clk), .rst_n(rst_n), .valid(s_valid), .ready(s_ready),
        .payload(payload), .top_last(s_last[(LANES-1)*DIMS +: DIMS]),
        .hold_err(hold_err), .gap_err(gap_err)
    );

    always_comb begin
        det         = rule_err;
        det[E_HOLD] = hold_err;
        det[E_GAP]  = gap_err;
    end

    smon_err_bank u_bank (
        .clk(clk), .rst_n(rst_n), .valid(s_valid), .det(det),
        .sticky(err_sticky), .pulse(err_pulse)
    );

    p_stall_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(s_valid) && !$past(s_ready) && !s_valid) |=> err_sticky[E_HOLD]);

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && (s_hi_idx < s_lo_idx)) |=> err_sticky[E_RNG]);

    generate
        if (CPLX < 8) begin : g_uniform_chk
            p_strb_mix_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (s_valid && (|s_lane_en) && !(&s_lane_en)) |=> err_sticky[E_STRB]);
        end
        if (CPLX < 3) begin : g_gap_chk
            p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(s_valid && s_ready) &&
                 ($past(s_last[(LANES-1)*DIMS +: DIMS]) == '0) && !s_valid) |=> err_sticky[E_GAP]);
        end
    endgenerate
endmodule

// File: tb/stream_rule_monitor_test.sv
module stream_rule_monitor_test;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s_valid = 1'b0, s_ready = 1'b0;
    logic [23:0] s_data = '0;
    logic [5:0] s_last = '0;
    logic [1:0] s_lo_idx = '0, s_hi_idx = '0;
    logic [2:0] s_lane_en = '0;
    logic [3:0] s_user = 4'h5;
    logic [9:0] stk_lo, pls_lo, stk_hi, pls_hi;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_rule_monitor #(.CPLX(1)) uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_last(s_last), .s_lo_idx(s_lo_idx), .s_hi_idx(s_hi_idx), .s_lane_en(s_lane_en),
        .s_user(s_user), .err_sticky(stk_lo), .err_pulse(pls_lo));

    stream_rule_monitor #(.CPLX(8)) uut_hi (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
        .s_last(s_last), .s_lo_idx(s_lo_idx), .s_hi_idx(s_hi_idx), .s_lane_en(s_lane_en),
        .s_user(s_user), .err_sticky(stk_hi), .err_pulse(pls_hi));

    // beat: [22]valid [21]ready [20:15]last [14:13]lo [12:11]hi [10:8]strobe [7:0]data
    // vector: [65:43] beat A, [42:20] beat B, [19:10] sticky at level 1, [9:0] at level 8
    localparam logic [65:0] VEC [NV] = '{
        {1'b1,1'b1,6'b110000,2'd0,2'd2,3'b111,8'h11, 23'd0, 10'h000, 10'h000},
        {1'b1,1'b1,6'b000000,2'd2,2'd1,3'b111,8'h11, 23'd0, 10'h164, 10'h004},
        {1'b1,1'b1,6'b110000,2'd0,2'd3,3'b111,8'h11, 23'd0, 10'h004, 10'h004},
        {1'b1,1'b1,6'b110000,2'd0,2'd2,3'b011,8'h11, 23'd0, 10'h088, 10'h000},
        {1'b1,1'b1,6'b000011,2'd0,2'd2,3'b111,8'h11,
         1'b1,1'b1,6'b110000,2'd0,2'd2,3'b111,8'h11, 10'h010, 10'h000},
        {1'b1,1'b0,6'b110000,2'd0,2'd2,3'b111,8'h11,
         1'b1,1'b1,6'b110000,2'd0,2'd2,3'b111,8'h22, 10'h002, 10'h002},
        {1'b1,1'b0,6'b110000,2'd0,2'd2,3'b111,8'h11, 23'd0, 10'h002, 10'h002},
        {1'b1,1'b1,6'b100000,2'd0,2'd2,3'b111,8'h11, 23'd0, 10'h380, 10'h200},
        {1'b1,1'b1,6'b110000,2'd0,2'd2,3'b000,8'h11, 23'd0, 10'h000, 10'h000},
        {1'b1,1'b1,6'b000000,2'd0,2'd2,3'b111,8'h11,
         1'b1,1'b1,6'b110000,2'd0,2'd2,3'b000,8'h11, 10'h080, 10'h000},
        {1'b1,1'b1,6'b110000,2'd1,2'd2,3'b111,8'h11, 23'd0, 10'h020, 10'h000},
        {1'b1,1'b1,6'b010000,2'd0,2'd2,3'b111,8'h11, 23'd0, 10'h100, 10'h000}
    };
    string tags [NV] = '{"R11 clean close", "R3 R6 R8 reversed indices", "R3 index past top",
                         "R4 R7 mixed strobe", "R5 low-lane flags", "R2 payload change",
                         "R2 valid drop in stall", "R7 R8 R9 bad nesting", "R7 R9 empty sequence",
                         "R7 postponed close", "R6 lower index", "R8 partial top close"};

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [22:0] b);
        s_valid   = b[22];
        s_ready   = b[21];
        s_last    = b[20:15];
        s_lo_idx  = b[14:13];
        s_hi_idx  = b[12:11];
        s_lane_en = b[10:8];
        s_data    = {3{b[7:0]}};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive('0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: clean reset clears every flag
        do_reset();
        check("R1 clean reset level1", stk_lo, 10'h000);
        check("R1 clean reset level8", stk_hi, 10'h000);

        for (int v = 0; v < NV; v++) begin
            do_reset();
            drive(VEC[v][65:43]);
            @(negedge clk);
            drive(VEC[v][42:20]);
            @(negedge clk);
            drive('0);
            @(negedge clk);
            @(negedge clk);
            check({tags[v], " level1"}, stk_lo, VEC[v][19:10]);
            check({tags[v], " level8"}, stk_hi, VEC[v][9:0]);
        end

        // R1: valid high during reset
        @(negedge clk);
        rst_n = 1'b0;
        drive({1'b1,1'b1,6'b110000,2'd0,2'd2,3'b111,8'h11});
        @(negedge clk);
        check("R1 pulse in reset", pls_lo, 10'h001);
        @(negedge clk);
        rst_n = 1'b1;
        drive('0);
        check("R1 reset-class sticky level1", stk_lo, 10'h001);
        check("R1 reset-class sticky level8", stk_hi, 10'h001);

        // R10: pulse only on first detection, sticky persists
        do_reset();
        drive({1'b1,1'b1,6'b110000,2'd1,2'd2,3'b111,8'h11});
        #1;
        check("R10 first pulse", pls_lo, 10'h020);
        check("R6 lower index ignored at level8", pls_hi, 10'h000);
        @(negedge clk);
        check("R10 no repeat pulse", pls_lo, 10'h000);
        check("R10 sticky set", stk_lo, 10'h020);
        drive('0);
        repeat (3) @(negedge clk);
        check("R10 sticky kept", stk_lo, 10'h020);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule